// File: doc/BRIEF.md
# Snooping Three-State Line Coherence Controller

This block keeps one cache line coherent in a bus-based multiprocessor that uses write-invalidate. It holds the line's address tag and its coherence state: Invalid, Shared (clean, read-only, possibly held by several caches) or Exclusive (dirty, held only here, writable). Processor reads and writes are answered with a same-cycle hit or miss pulse. A miss starts a bus operation. Snooped read misses and write misses from other caches that match the line downgrade or invalidate it.

Outgoing bus operations are held on a valid/ready request channel until they are accepted. A dirty line being replaced is written back first, and only then is the miss itself issued. The line stays marked in-progress from the start of an operation until the bus sends a completion pulse. While it is marked, no new operation starts, so processor requests stall. A write to a Shared line is issued as a full write-miss, not as an upgrade.

Top module: `msi_line_ctrl`

## Requirements
- R1: After reset the line is Invalid (line_state_o = 0; the encodings are Invalid 0, Shared 1, Exclusive 2), bus_req_valid_o is 0 and busy_o is 0.
- R2: A processor read that misses gives a one-cycle cpu_miss_o and issues a read-miss operation (bus op code 0) for the requested address. The line then becomes Shared with that tag.
- R3: A processor write to an Invalid line, to a Shared line, or to a line holding another tag that is not Exclusive gives cpu_miss_o and issues a write-miss (op code 1) for the requested address. The line becomes Exclusive. A Shared line that matches the tag is handled this way too, with no upgrade operation.
- R4: A miss to a different address while the line is Exclusive first issues a write-back (op code 2) carrying the old tag. It then issues a read-miss (line becomes Shared) or a write-miss (line stays Exclusive) for the new address.
- R5: A read that matches the tag in Shared or Exclusive, and a write that matches the tag in Exclusive, give cpu_hit_o, start no bus operation and leave the state unchanged.
- R6: A snooped read miss (snoop op 0) that matches the tag in Exclusive issues a write-back of the tag and moves the line to Shared. In Shared it changes nothing.
- R7: A snooped write miss (snoop op 1) that matches the tag moves the line to Invalid. It issues a write-back first only if the line was Exclusive.
- R8: A snoop whose address differs from the tag, or any snoop while the line is Invalid, has no effect on state or bus.
- R9: busy_o is 1 from the cycle after an operation starts until the cycle after bus_done_i arrives in the waiting phase. While it is 1, cpu_ready_o stays 0. A bus_done_i while idle has no effect.
- R10: While bus_req_valid_o is 1 and bus_req_ready_i is 0, the request valid, op and address hold steady.
- R11: When a matching snoop and a processor request arrive in the same cycle, the snoop is applied and the processor request is not accepted (cpu_ready_o = 0) in that cycle. The request is then judged against the updated state.
- R12: A matching snoop while busy_o is 1 still changes the state as in R6 and R7 but issues no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_valid_i | input | 1 | Processor request present |
| cpu_write_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | AW | Processor block address |
| cpu_ready_o | output | 1 | Request accepted this cycle |
| cpu_hit_o | output | 1 | Accepted request hit |
| cpu_miss_o | output | 1 | Accepted request missed |
| snoop_valid_i | input | 1 | Snooped bus operation present |
| snoop_op_i | input | 1 | 0 = read miss, 1 = write miss |
| snoop_addr_i | input | AW | Snooped block address |
| bus_req_valid_o | output | 1 | Outgoing bus request valid |
| bus_req_op_o | output | 2 | 0 read miss, 1 write miss, 2 write-back |
| bus_req_addr_o | output | AW | Outgoing request address |
| bus_req_ready_i | input | 1 | Bus accepts the request |
| bus_done_i | input | 1 | Operation completion pulse |
| busy_o | output | 1 | Operation in progress for the line |
| line_state_o | output | 2 | Current coherence state |

## Verification
The assertions check four things on every cycle: the request channel holds steady under back-pressure, a write-back that precedes a miss is followed by the miss, no request is accepted while the line is in progress, and a miss always sets the in-progress flag. They also check that a hit leaves the state and the bus quiet and that a matching snooped write miss leaves the line Invalid. Only the bench scenarios can show the right address and op sequence for each transition. The same holds for the snoop-first ordering in a same-cycle collision, the suppressed write-back for snoops during an operation, and the ignored stray completion pulse.

// File: rtl/msi_pkg.sv
package msi_pkg;
  typedef enum logic [1:0] {LINE_I = 2'd0, LINE_S = 2'd1, LINE_E = 2'd2} line_state_e;
  typedef enum logic [1:0] {BOP_RD = 2'd0, BOP_WR = 2'd1, BOP_WB = 2'd2} bus_op_e;
  typedef enum logic [1:0] {PH_IDLE, PH_WB, PH_MISS, PH_WAIT} phase_e;
endpackage

// File: rtl/msi_lookup.sv
module msi_lookup
  import msi_pkg::*;
#(
  parameter int AW = 16
) (
  input  line_state_e   state_i,
  input  logic [AW-1:0] tag_i,
  input  logic [AW-1:0] cpu_addr_i,
  input  logic          cpu_write_i,
  input  logic          snoop_valid_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          cpu_hit_o,
  output logic          replace_o,
  output logic          snoop_match_o
);
  logic cpu_tag_eq;

  assign cpu_tag_eq    = (tag_i == cpu_addr_i);
  assign cpu_hit_o     = cpu_tag_eq && (cpu_write_i ? (state_i == LINE_E) : (state_i != LINE_I));
  // dirty victim must leave before the new block is requested
  assign replace_o     = !cpu_tag_eq && (state_i == LINE_E);
  assign snoop_match_o = snoop_valid_i && (state_i != LINE_I) && (snoop_addr_i == tag_i);
endmodule

// File: rtl/msi_bus_seq.sv
module msi_bus_seq
  import msi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          need_wb_i,
  input  logic          need_miss_i,
  input  logic [AW-1:0] wb_addr_i,
  input  bus_op_e       miss_op_i,
  input  logic [AW-1:0] miss_addr_i,
  input  logic          bus_ready_i,
  input  logic          bus_done_i,
  output logic          bus_valid_o,
  output bus_op_e       bus_op_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          busy_o
);
  phase_e        phase_q;
  logic          follow_q;
  logic [AW-1:0] wb_addr_q;
  bus_op_e       op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      follow_q  <= 1'b0;
      wb_addr_q <= '0;
      op_q      <= BOP_RD;
    end else begin
      case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q   <= need_wb_i ? PH_WB : PH_MISS;
          follow_q  <= need_miss_i;
          wb_addr_q <= wb_addr_i;
          op_q      <= miss_op_i;
        end
        PH_WB:   if (bus_ready_i) phase_q <= follow_q ? PH_MISS : PH_WAIT;
        PH_MISS: if (bus_ready_i) phase_q <= PH_WAIT;
        PH_WAIT: if (bus_done_i) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign bus_valid_o = (phase_q == PH_WB) || (phase_q == PH_MISS);
  assign bus_op_o    = (phase_q == PH_WB) ? BOP_WB : op_q;
  assign bus_addr_o  = (phase_q == PH_WB) ? wb_addr_q : miss_addr_i;
  assign busy_o      = (phase_q != PH_IDLE);

  // R10
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && !bus_ready_i |=> bus_valid_o && $stable(bus_op_o) && $stable(bus_addr_o));

  // R4
  wb_then_miss_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_valid_o && bus_ready_i && bus_op_o == BOP_WB && follow_q |=> bus_valid_o && bus_op_o != BOP_WB);
endmodule

// File: rtl/msi_line_ctrl.sv
module msi_line_ctrl
  import msi_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpu_valid_i,
  input  logic          cpu_write_i,
  input  logic [AW-1:0] cpu_addr_i,
  output logic          cpu_ready_o,
  output logic          cpu_hit_o,
  output logic          cpu_miss_o,
  input  logic          snoop_valid_i,
  input  logic          snoop_op_i,
  input  logic [AW-1:0] snoop_addr_i,
  output logic          bus_req_valid_o,
  output logic [1:0]    bus_req_op_o,
  output logic [AW-1:0] bus_req_addr_o,
  input  logic          bus_req_ready_i,
  input  logic          bus_done_i,
  output logic          busy_o,
  output logic [1:0]    line_state_o
);
  line_state_e   state_q;
  logic [AW-1:0] tag_q;
  logic          lk_hit, lk_replace, snoop_match;
  logic          accept, miss_take, snoop_wb, seq_busy;
  bus_op_e       seq_op;

  msi_lookup #(.AW(AW)) u_lookup (
    .state_i      (state_q),
    .tag_i        (tag_q),
    .cpu_addr_i   (cpu_addr_i),
    .cpu_write_i  (cpu_write_i),
    .snoop_valid_i(snoop_valid_i),
    .snoop_addr_i (snoop_addr_i),
    .cpu_hit_o    (lk_hit),
    .replace_o    (lk_replace),
    .snoop_match_o(snoop_match)
  );

  // snoop wins a same-cycle collision; cpu retries next cycle
  assign accept    = cpu_valid_i && !seq_busy && !snoop_match;
  assign miss_take = accept && !lk_hit;
  assign snoop_wb  = snoop_match && !seq_busy && (state_q == LINE_E);

  msi_bus_seq #(.AW(AW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (miss_take || snoop_wb),
    .need_wb_i  ((miss_take && lk_replace) || snoop_wb),
    .need_miss_i(miss_take),
    .wb_addr_i  (tag_q),
    .miss_op_i  (cpu_write_i ? BOP_WR : BOP_RD),
    .miss_addr_i(tag_q),
    .bus_ready_i(bus_req_ready_i),
    .bus_done_i (bus_done_i),
    .bus_valid_o(bus_req_valid_o),
    .bus_op_o   (seq_op),
    .bus_addr_o (bus_req_addr_o),
    .busy_o     (seq_busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= LINE_I;
      tag_q   <= '0;
    end else if (snoop_match) begin
      if (snoop_op_i)                state_q <= LINE_I;
      else if (state_q == LINE_E)    state_q <= LINE_S;
    end else if (miss_take) begin
      state_q <= cpu_write_i ? LINE_E : LINE_S;
      tag_q   <= cpu_addr_i;
    end
  end

  assign cpu_ready_o  = accept;
  assign cpu_hit_o    = accept && lk_hit;
  assign cpu_miss_o   = miss_take;
  assign bus_req_op_o = seq_op;
  assign busy_o       = seq_busy;
  assign line_state_o = state_q;

  // R9
  no_accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !cpu_ready_o);

  // R9
  miss_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_miss_o |=> busy_o);

  // R5
  hit_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_hit_o |=> $stable(line_state_o) && !bus_req_valid_o);

  // R7
  snoop_inval_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snoop_match && snoop_op_i |=> line_state_o == LINE_I);
endmodule

// File: tb/msi_line_ctrl_bench.sv
module msi_line_ctrl_bench;
  import msi_pkg::*;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic          snoop_valid = 1'b0, snoop_op = 1'b0;
  logic [AW-1:0] snoop_addr = '0;
  logic          bus_ready = 1'b0, bus_done = 1'b0;
  logic          cpu_ready, cpu_hit, cpu_miss, bus_valid, busy;
  logic [1:0]    bus_op, line_state;
  logic [AW-1:0] bus_addr;

  int nchk = 0, nfail = 0;
  int m_st = 0;
  logic [AW-1:0] m_tag = '0;
  bit m_busy = 0;
  int unsigned seed = 32'h5eed_1234;

  always #10 clk = ~clk;

  msi_line_ctrl #(.AW(AW)) u_msi_line_ctrl (
    .clk_i(clk), .rst_ni(rst_ni),
    .cpu_valid_i(cpu_valid), .cpu_write_i(cpu_write), .cpu_addr_i(cpu_addr),
    .cpu_ready_o(cpu_ready), .cpu_hit_o(cpu_hit), .cpu_miss_o(cpu_miss),
    .snoop_valid_i(snoop_valid), .snoop_op_i(snoop_op), .snoop_addr_i(snoop_addr),
    .bus_req_valid_o(bus_valid), .bus_req_op_o(bus_op), .bus_req_addr_o(bus_addr),
    .bus_req_ready_i(bus_ready), .bus_done_i(bus_done),
    .busy_o(busy), .line_state_o(line_state)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  // called at a negedge with a request expected
  task automatic serve(input int op, input logic [AW-1:0] a, input string req);
    chk(bus_valid == 1'b1, req, "bus valid", int'(bus_valid), 1);
    chk(int'(bus_op) == op, req, "bus op", int'(bus_op), op);
    chk(bus_addr == a, req, "bus addr", int'(bus_addr), int'(a));
    if ($urandom % 2 == 1) begin
      @(posedge clk); @(negedge clk);
      chk(bus_valid && int'(bus_op) == op && bus_addr == a, "R10", "held request",
          int'(bus_op), op);
    end
    bus_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_ready = 1'b0;
  endtask

  task automatic finish_op();
    chk(busy == 1'b1, "R9", "busy before done", int'(busy), 1);
    chk(bus_valid == 1'b0, "R9", "no request while waiting", int'(bus_valid), 0);
    bus_done = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_done = 1'b0;
    m_busy = 0;
    chk(busy == 1'b0, "R9", "busy after done", int'(busy), 0);
  endtask

  task automatic cpu_op(input bit w, input logic [AW-1:0] a, input bit do_finish);
    bit exp_hit, repl;
    logic [AW-1:0] old;
    string req;
    exp_hit = (m_tag == a) && (w ? (m_st == 2) : (m_st != 0));
    repl = !exp_hit && (m_st == 2) && (m_tag != a);
    old = m_tag;
    req = exp_hit ? "R5" : (repl ? "R4" : (w ? "R3" : "R2"));
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = w; cpu_addr = a;
    #1;
    chk(cpu_ready == 1'b1, "R9", "ready when idle", int'(cpu_ready), 1);
    chk(cpu_hit == exp_hit, req, "hit", int'(cpu_hit), int'(exp_hit));
    chk(cpu_miss == !exp_hit, req, "miss", int'(cpu_miss), int'(!exp_hit));
    @(posedge clk); @(negedge clk);
    cpu_valid = 1'b0;
    if (exp_hit) begin
      chk(bus_valid == 1'b0, "R5", "no bus op on hit", int'(bus_valid), 0);
    end else begin
      m_st = w ? 2 : 1;
      m_tag = a;
      m_busy = 1;
      if (repl) serve(2, old, "R4");
      serve(w ? 1 : 0, a, req);
      if (do_finish) finish_op();
    end
    chk(int'(line_state) == m_st, req, "state", int'(line_state), m_st);
  endtask

  task automatic snoop(input bit op, input logic [AW-1:0] a);
    bit match, wb;
    logic [AW-1:0] old;
    string req;
    match = (m_st != 0) && (a == m_tag);
    wb = match && (m_st == 2) && !m_busy;
    old = m_tag;
    req = !match ? "R8" : (m_busy ? "R12" : (op ? "R7" : "R6"));
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = op; snoop_addr = a;
    @(posedge clk); @(negedge clk);
    snoop_valid = 1'b0;
    if (match) m_st = op ? 0 : ((m_st == 2) ? 1 : m_st);
    chk(int'(line_state) == m_st, req, "snoop state", int'(line_state), m_st);
    if (wb) begin
      m_busy = 1;
      serve(2, old, req);
      finish_op();
    end else begin
      chk(bus_valid == 1'b0, req, "no write-back", int'(bus_valid), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(seed));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_ni = 1'b1;
    #1;
    chk(line_state == 2'd0, "R1", "reset state", int'(line_state), 0);
    chk(bus_valid == 1'b0, "R1", "reset bus valid", int'(bus_valid), 0);
    chk(busy == 1'b0, "R1", "reset busy", int'(busy), 0);

    cpu_op(0, 16'h10, 1);   // R2
    cpu_op(0, 16'h10, 1);   // R5 read hit in S
    cpu_op(1, 16'h10, 1);   // R3 write to matching S line: full write miss
    cpu_op(1, 16'h10, 1);   // R5
    cpu_op(0, 16'h10, 1);   // R5
    snoop(0, 16'h10);       // R6 write-back, to S
    snoop(0, 16'h10);       // R6 in S: no change
    snoop(1, 16'h11);       // R8 other address
    snoop(1, 16'h10);       // R7 S to I, no write-back
    snoop(0, 16'h10);       // R8 line invalid
    cpu_op(1, 16'h12, 1);   // R3
    cpu_op(0, 16'h13, 1);   // R4 replacement then read miss
    cpu_op(1, 16'h12, 1);   // R3 from S other tag
    cpu_op(1, 16'h14, 1);   // R4 replacement then write miss
    snoop(1, 16'h14);       // R7 E to I with write-back

    // R11 collision: snoop first, cpu stalled one cycle
    cpu_op(0, 16'h15, 1);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_write = 1'b0; cpu_addr = 16'h15;
    snoop_valid = 1'b1; snoop_op = 1'b1; snoop_addr = 16'h15;
    #1;
    chk(cpu_ready == 1'b0, "R11", "stalled on collision", int'(cpu_ready), 0);
    @(posedge clk); @(negedge clk);
    snoop_valid = 1'b0;
    #1;
    chk(cpu_ready == 1'b1, "R11", "accepted after snoop", int'(cpu_ready), 1);
    chk(cpu_miss == 1'b1, "R11", "miss after invalidation", int'(cpu_miss), 1);
    @(posedge clk); @(negedge clk);
    m_st = 1; m_tag = 16'h15; m_busy = 1;
    #1;
    chk(cpu_ready == 1'b0, "R9", "blocked while busy", int'(cpu_ready), 0);
    cpu_valid = 1'b0;
    serve(0, 16'h15, "R2");
    snoop(1, 16'h15);       // R12 S to I while busy
    finish_op();
    // R9 stray done while idle
    @(negedge clk); bus_done = 1'b1;
    @(posedge clk); @(negedge clk); bus_done = 1'b0;
    chk(busy == 1'b0, "R9", "stray done ignored", int'(busy), 0);
    chk(bus_valid == 1'b0, "R9", "stray done no request", int'(bus_valid), 0);
    // R12 E line snooped while its operation is pending
    cpu_op(1, 16'h17, 0);
    snoop(0, 16'h17);
    finish_op();
    chk(int'(line_state) == 1, "R12", "state after busy snoop", int'(line_state), 1);

    for (int i = 0; i < 400; i++) begin
      logic [AW-1:0] a;
      a = AW'(16'h20 + ($urandom % 3));
      if ($urandom % 5 < 3) cpu_op(1'($urandom % 2), a, 1);
      else snoop(1'($urandom % 2), a);
    end
    summary();
  end
endmodule